// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block keeps the active-lane mask of a multi-lane SIMD thread processor while a warp of threads passes through nested conditional branches. Every lane executes each instruction; the active mask only decides which lanes are allowed to write back a result. When a branch diverges, the current mask is saved on a stack and the active mask is narrowed to the lanes whose predicate bit is set. Switching to the else path flips the mask within the saved one, and reconvergence pops the saved mask back.

Commands arrive as three plain strobes (enter, flip, leave) together with a per-lane predicate vector. Commands are control pins, not a stream: they carry no handshake and there is no back-pressure, and each strobe takes effect at the next rising clock edge. A second output group gives per-lane write enables for the retiring instruction and a skip hint that lets the front end jump over a path on which no lane is active. Misuse (overflow, underflow, two commands at once) raises a one-cycle error pulse and leaves all state as it was.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset the active mask is all ones, the error flag is low and the stack is empty, so a leave or flip command issued first is rejected as an error.
- R2: An enter command (`br_enter`) saves the current mask on the stack and, at the next edge, sets the active mask to the old mask AND `lane_pred`.
- R3: A flip command (`br_flip`) sets the active mask to the saved top entry AND NOT the current active mask; the stack itself is unchanged.
- R4: A leave command (`br_leave`) restores the active mask to the top entry and removes that entry; entries come back in last-in first-out order.
- R5: An enter command when the stack already holds DEPTH entries is rejected: error flag high, active mask and stack unchanged.
- R6: A flip or leave command on an empty stack is rejected: error flag high, active mask and stack unchanged.
- R7: When more than one command strobe is high in the same cycle, none is executed and the error flag is raised.
- R8: `lane_wen` equals the active mask in every lane when `retire` is high and is all zeros when `retire` is low (combinational).
- R9: `path_skip` is high exactly when the active mask is all zeros.
- R10: `cmd_err` is high for the single cycle that follows a rejected command and low after every accepted command or idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| br_enter | input | 1 | Divergent branch: save mask and narrow by predicate |
| br_flip | input | 1 | Switch to the other path within the saved mask |
| br_leave | input | 1 | Reconverge: restore saved mask |
| lane_pred | input | LANES | Per-lane predicate, bit i for lane i |
| retire | input | 1 | An instruction retires this cycle |
| active_mask | output | LANES | Current active-lane mask, bit i for lane i |
| lane_wen | output | LANES | Per-lane result write enable |
| path_skip | output | 1 | Active mask is empty; path may be skipped |
| cmd_err | output | 1 | Previous command was rejected |

## Verification
The hardest state to reach is a stack filled to its full depth with a distinct mask at every level, followed by a rejected enter and then an unwinding that must return each level's mask in reverse order. The bench drives a chain of DEPTH enters with a different predicate at each step, adds one more enter to provoke the overflow, then interleaves flips and leaves down to an empty stack and one further underflow; a long pseudo-random command stream weighted toward enters then revisits full and empty boundaries with nested flips.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_ENTER = 2'd1,
    OP_FLIP  = 2'd2,
    OP_LEAVE = 2'd3
  } mask_op_e;
endpackage

// File: rtl/mask_cmd_decode.sv
module mask_cmd_decode
  import simt_mask_pkg::*;
(
  input  logic     enter_i,
  input  logic     flip_i,
  input  logic     leave_i,
  output mask_op_e op_o,
  output logic     clash_o
);
  logic [1:0] n_cmd;

  always_comb begin
    n_cmd   = 2'(enter_i) + 2'(flip_i) + 2'(leave_i);
    clash_o = (n_cmd > 2'd1);
    op_o    = OP_IDLE;
    if (!clash_o) begin
      if (enter_i)      op_o = OP_ENTER;
      else if (flip_i)  op_o = OP_FLIP;
      else if (leave_i) op_o = OP_LEAVE;
    end
  end
endmodule

// File: rtl/mask_lifo.sv
module mask_lifo #(
  parameter int LANES = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [LANES-1:0] wdata_i,
  output logic [LANES-1:0] top_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int SPW  = $clog2(DEPTH + 1);
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SPW-1:0]   sp_q;
  logic [SPW-1:0]   top_idx;
  logic [LANES-1:0] entry_q [DEPTH];

  assign full_o  = (sp_q == SPW'(DEPTH));
  assign empty_o = (sp_q == '0);
  assign top_idx = sp_q - 1'b1;
  assign top_o   = empty_o ? '0 : entry_q[top_idx[IDXW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n)      sp_q <= '0;
    else if (push_i) sp_q <= sp_q + 1'b1;
    else if (pop_i)  sp_q <= sp_q - 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)                            entry_q[g] <= '0;
      else if (push_i && sp_q == SPW'(g))    entry_q[g] <= wdata_i;
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |=> !(sp_q > SPW'(DEPTH)));

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/mask_next_calc.sv
module mask_next_calc
  import simt_mask_pkg::*;
#(
  parameter int LANES = 32
) (
  input  mask_op_e         op_i,
  input  logic [LANES-1:0] cur_i,
  input  logic [LANES-1:0] pred_i,
  input  logic [LANES-1:0] top_i,
  output logic [LANES-1:0] next_o
);
  always_comb begin
    unique case (op_i)
      OP_ENTER: next_o = cur_i & pred_i;
      OP_FLIP:  next_o = top_i & ~cur_i;
      OP_LEAVE: next_o = top_i;
      default:  next_o = cur_i;
    endcase
  end
endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
  import simt_mask_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_enter,
  input  logic             br_flip,
  input  logic             br_leave,
  input  logic [LANES-1:0] lane_pred,
  input  logic             retire,
  output logic [LANES-1:0] active_mask,
  output logic [LANES-1:0] lane_wen,
  output logic             path_skip,
  output logic             cmd_err
);
  mask_op_e         op;
  logic             clash, full, empty, legal;
  logic [LANES-1:0] top, next_mask, active_q;
  logic             err_q;

  mask_cmd_decode u_dec (
    .enter_i(br_enter), .flip_i(br_flip), .leave_i(br_leave),
    .op_o(op), .clash_o(clash)
  );

  always_comb begin
    legal = !clash;
    if (op == OP_ENTER && full)                      legal = 1'b0;
    if ((op == OP_FLIP || op == OP_LEAVE) && empty)  legal = 1'b0;
  end

  mask_lifo #(.LANES(LANES), .DEPTH(DEPTH)) u_lifo (
    .clk(clk), .rst_n(rst_n),
    .push_i(legal && op == OP_ENTER),
    .pop_i(legal && op == OP_LEAVE),
    .wdata_i(active_q),
    .top_o(top), .full_o(full), .empty_o(empty)
  );

  mask_next_calc #(.LANES(LANES)) u_next (
    .op_i(op), .cur_i(active_q), .pred_i(lane_pred), .top_i(top),
    .next_o(next_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= '1;
      err_q    <= 1'b0;
    end else begin
      if (legal) active_q <= next_mask;
      err_q <= !legal;
    end
  end

  assign active_mask = active_q;
  assign lane_wen    = retire ? active_q : '0;
  assign path_skip   = (active_q == '0);
  assign cmd_err     = err_q;

  // R2
  enter_narrows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_enter && !br_flip && !br_leave && !full)
      |=> ((active_q & ~$past(active_q)) == '0));

  // R3
  flip_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_flip && !br_enter && !br_leave && !empty)
      |=> ((active_q & $past(active_q)) == '0));

  // R5
  err_holds_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $stable(active_q));

  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(br_enter || br_flip || br_leave));

  // R7
  clash_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({br_enter, br_flip, br_leave}) > 1) |=> cmd_err);
endmodule

// File: tb/sim_simt_mask_stack.sv
module sim_simt_mask_stack;
  localparam int LANES = 32;
  localparam int DEPTH = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             br_enter = 1'b0, br_flip = 1'b0, br_leave = 1'b0, retire = 1'b0;
  logic [LANES-1:0] lane_pred = '0;
  logic [LANES-1:0] active_mask, lane_wen;
  logic             path_skip, cmd_err;

  int n_cmp = 0, n_bad = 0;
  logic [LANES-1:0] m_act;
  logic             m_err;
  logic [LANES-1:0] m_stk [$];
  logic [31:0]      lfsr = 32'hACE1_2468;

  always #5 clk = ~clk;

  simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .br_enter(br_enter), .br_flip(br_flip),
    .br_leave(br_leave), .lane_pred(lane_pred), .retire(retire),
    .active_mask(active_mask), .lane_wen(lane_wen),
    .path_skip(path_skip), .cmd_err(cmd_err)
  );

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic chk(input string req, input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // compare registered outputs, drive a command, check write enables, advance model
  task automatic step(input logic e, input logic f, input logic l,
                      input logic [LANES-1:0] p, input logic rt);
    int n;
    @(negedge clk);
    chk("R1/R2/R3/R4 active_mask", active_mask, m_act);
    chk("R9 path_skip", LANES'(path_skip), LANES'(m_act == '0));
    chk("R10 cmd_err", LANES'(cmd_err), LANES'(m_err));
    br_enter = e; br_flip = f; br_leave = l; lane_pred = p; retire = rt;
    #1;
    chk("R8 lane_wen", lane_wen, rt ? m_act : '0);
    n = int'(e) + int'(f) + int'(l);
    m_err = 1'b0;
    if (n > 1) m_err = 1'b1;                                 // R7
    else if (e) begin
      if (m_stk.size() == DEPTH) m_err = 1'b1;               // R5
      else begin m_stk.push_back(m_act); m_act = m_act & p; end
    end else if (f) begin
      if (m_stk.size() == 0) m_err = 1'b1;                   // R6
      else m_act = m_stk[$] & ~m_act;
    end else if (l) begin
      if (m_stk.size() == 0) m_err = 1'b1;                   // R6
      else m_act = m_stk.pop_back();
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin
    m_act = '1; m_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, then leave and flip on empty stack
    step(0, 0, 0, '0, 1);
    step(0, 0, 1, '0, 0);          // R6 leave underflow
    step(0, 1, 0, '0, 1);          // R6 flip underflow
    // R2/R3/R4 simple if/else
    step(1, 0, 0, 32'h0000_FFFF, 1);
    step(0, 1, 0, '0, 1);
    step(0, 0, 1, '0, 1);
    // R9: empty path
    step(1, 0, 0, '0, 1);
    step(0, 1, 0, '0, 0);
    step(0, 0, 1, '0, 0);
    // R5: fill to depth with distinct predicates, then overflow
    for (int i = 0; i < DEPTH; i++)
      step(1, 0, 0, ~(32'h1 << (i * 3)), 1);
    step(1, 0, 0, 32'h0, 1);
    // R7: two and three strobes at once
    step(1, 0, 1, '1, 0);
    step(1, 1, 1, '1, 0);
    // unwind with flips, R4 LIFO order
    for (int i = 0; i < DEPTH; i++) begin
      step(0, 1, 0, '0, 1);
      step(0, 0, 1, '0, 1);
    end
    step(0, 0, 1, '0, 1);          // R6 underflow again
    // pseudo-random stream
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] c;
      lfsr = nxt(lfsr);
      c = lfsr[2:0];
      lfsr = nxt(lfsr);
      case (c)
        3'd0, 3'd1, 3'd2: step(1, 0, 0, lfsr, lfsr[5]);
        3'd3:             step(0, 1, 0, lfsr, lfsr[5]);
        3'd4, 3'd5:       step(0, 0, 1, lfsr, lfsr[5]);
        3'd6:             step(lfsr[7], lfsr[8], lfsr[9], lfsr, lfsr[5]);
        default:          step(0, 0, 0, lfsr, lfsr[5]);
      endcase
    end
    step(0, 0, 0, '0, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule